// File: doc/BRIEF.md
# Bidirectional Port with Change and Edge Interrupts

This block is an 8-bit general-purpose port. Every pin has a direction bit, an output latch and a read path that returns the pin level after synchronization. Pins set as inputs can have a weak pull-up, and one global disable bit controls all of the pull-ups. Pin 0 also serves as an external interrupt input, and a stored polarity bit selects which edge it responds to.

The upper four pins raise a change flag when an input level differs from a snapshot of that pin. The snapshot does not follow the previous clock. It is refreshed only when software reads the port or writes the output latch. A read therefore ends the mismatch, and the flag can be cleared only after that. Pin levels pass through a two-stage synchronizer that samples once per instruction cycle of `CYC_DIV` clocks. A pulse that falls entirely between two samples is never seen.

Top module: `pinport_irq`

## Requirements
- R1: After reset, all pins are inputs (`pin_oe` = 0x00), the output latch holds 0x00, the pull-up disable bit is 1 (`pu_en` = 0x00), the edge polarity is rising, and both `intf` and `chgf` are 0.
- R2: A `dir_wr` strobe loads `wdata` into the direction register, where bit value 1 means input. `pin_oe[i]` is the inverse of direction bit i. A `lat_wr` strobe loads `wdata` into the latch, which drives `pin_out`.
- R3: `rdata` returns the synchronized pin levels whatever the direction or latch contents are. A latch write does not change `rdata`.
- R4: `pu_en[i]` is 1 only when the stored disable bit is 0 and pin i is an input.
- R5: Only pins 7 to 4 take part in change detection, and only while they are inputs. A change on pins 3 to 0, or on an upper pin set as output, leaves `chgf` at 0.
- R6: `chgf` is set while any enabled upper pin differs from its snapshot. A `chgf_clr` strobe has no effect while a mismatch remains. After a `port_rd` strobe refreshes the snapshot, a later clear drops the flag.
- R7: A `lat_wr` strobe also refreshes the snapshot, so it ends a mismatch in the same way a read does.
- R8: `intf` is set on a rising edge of synchronized pin 0 when the stored polarity bit is 1, and on a falling edge when it is 0. The opposite edge has no effect. `intf_clr` clears the flag. A `cfg_wr` strobe stores `cfg_pu_off` and `cfg_rise`.
- R9: Pins are sampled on every `CYC_DIV`-th clock edge after reset is released. With the default of 4, these are edges 4, 8, 12 and so on. A level held for only one clock between two sample edges has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_in | input | 8 | Pin levels from the pads |
| lat_wr | input | 1 | Write strobe for the output latch |
| dir_wr | input | 1 | Write strobe for the direction register |
| cfg_wr | input | 1 | Write strobe for the pull-up disable and polarity bits |
| wdata | input | 8 | Write data for the latch and direction register |
| cfg_pu_off | input | 1 | Pull-up disable value stored by `cfg_wr` |
| cfg_rise | input | 1 | Edge polarity value stored by `cfg_wr` (1 = rising) |
| port_rd | input | 1 | Read strobe; refreshes the change snapshot |
| rdata | output | 8 | Synchronized pin levels |
| intf_clr | input | 1 | Clear strobe for `intf` |
| chgf_clr | input | 1 | Clear strobe for `chgf` |
| pin_out | output | 8 | Output drive values |
| pin_oe | output | 8 | Output enables (1 = driving) |
| pu_en | output | 8 | Weak pull-up enables |
| intf | output | 1 | Pin 0 edge interrupt flag |
| chgf | output | 1 | Upper-pin change interrupt flag |

## Verification
The assertions assume that write, read and clear strobes last one clock and come from a single-clocked host. They also assume that pin levels change only at clock boundaries, so the synchronizer output moves only on sample edges. The stimulus drives every input on the falling clock edge and holds each strobe for exactly one rising edge. After any pin change, it waits more than two sample periods before it expects a result. Glitch tests are placed just after a known sample edge, and the bench locates that edge by counting clocks from the release of reset.

// File: rtl/pinport_pkg.sv
// Shared types for the change-detect port.
// Assumes: one stored configuration word written by a single strobe.
package pinport_pkg;
    // Stored port configuration: pull-up disable and edge polarity.
    typedef struct packed {
        logic pu_off;
        logic rise;
    } pport_cfg_t;

    localparam pport_cfg_t CFG_RESET = '{pu_off: 1'b1, rise: 1'b1};
endpackage

// File: rtl/pinport_sync.sv
// Pin sampler: two-stage synchronizer advanced once per instruction cycle.
// Assumes: DIV >= 1; the counter starts at zero on the first edge after reset.
module pinport_sync #(
    parameter int W   = 8,
    parameter int DIV = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pins_raw,
    output logic [W-1:0] lvl,
    output logic         tick
);
    logic [W-1:0] stage1;

    generate
        if (DIV > 1) begin : g_div
            localparam int CW = $clog2(DIV);
            logic [CW-1:0] cnt;
            // Instruction-cycle counter.
            always_ff @(posedge clk) begin
                if (!rst_n)                    cnt <= '0;
                else if (cnt == CW'(DIV - 1))  cnt <= '0;
                else                           cnt <= cnt + 1'b1;
            end
            assign tick = (cnt == CW'(DIV - 1));
        end else begin : g_nodiv
            assign tick = 1'b1;
        end
    endgenerate

    // Two-flop synchronizer, advanced only on a sample tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            lvl    <= '0;
        end else if (tick) begin
            stage1 <= pins_raw;
            lvl    <= stage1;
        end
    end
endmodule

// File: rtl/pinport_regs.sv
// Port registers: output latch, direction, configuration and pull-up decode.
// Assumes: strobes last one clock; direction 1 means input.
module pinport_regs
    import pinport_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         lat_wr,
    input  logic         dir_wr,
    input  logic         cfg_wr,
    input  logic [W-1:0] wdata,
    input  logic         cfg_pu_off,
    input  logic         cfg_rise,
    output logic [W-1:0] lat,
    output logic [W-1:0] dir,
    output pport_cfg_t   cfg,
    output logic [W-1:0] pu_en
);
    // Output latch.
    always_ff @(posedge clk) begin
        if (!rst_n)      lat <= '0;
        else if (lat_wr) lat <= wdata;
    end

    // Direction register, all inputs at reset.
    always_ff @(posedge clk) begin
        if (!rst_n)      dir <= '1;
        else if (dir_wr) dir <= wdata;
    end

    // Configuration word.
    always_ff @(posedge clk) begin
        if (!rst_n)      cfg <= CFG_RESET;
        else if (cfg_wr) cfg <= '{pu_off: cfg_pu_off, rise: cfg_rise};
    end

    generate
        for (genvar i = 0; i < W; i++) begin : g_pu
            assign pu_en[i] = ~cfg.pu_off & dir[i];
        end
    endgenerate
endmodule

// File: rtl/pinport_chg.sv
// Change detector: compares upper input pins against a snapshot.
// Assumes: snap_load comes from port reads and latch writes; set wins over clear.
module pinport_chg #(
    parameter int NW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NW-1:0] lvl,
    input  logic [NW-1:0] is_in,
    input  logic          snap_load,
    input  logic          clr,
    output logic          flag
);
    logic [NW-1:0] snap;
    logic [NW-1:0] mis;

    generate
        for (genvar i = 0; i < NW; i++) begin : g_mis
            assign mis[i] = is_in[i] & (lvl[i] ^ snap[i]);
        end
    endgenerate

    // Snapshot refresh on read or latch write.
    always_ff @(posedge clk) begin
        if (!rst_n)         snap <= '0;
        else if (snap_load) snap <= lvl;
    end

    // Sticky flag; a live mismatch overrides a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)    flag <= 1'b0;
        else if (|mis) flag <= 1'b1;
        else if (clr)  flag <= 1'b0;
    end
endmodule

// File: rtl/pinport_edge.sv
// Edge interrupt on one synchronized pin with selectable polarity.
// Assumes: input is already synchronized; set wins over clear.
module pinport_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    input  logic rise_sel,
    input  logic clr,
    output logic flag
);
    logic prev;
    logic hit;

    assign hit = rise_sel ? (lvl & ~prev) : (~lvl & prev);

    // Previous level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= lvl;
    end

    // Sticky edge flag.
    always_ff @(posedge clk) begin
        if (!rst_n)   flag <= 1'b0;
        else if (hit) flag <= 1'b1;
        else if (clr) flag <= 1'b0;
    end
endmodule

// File: rtl/pinport_irq.sv
// Top: bidirectional port with upper-pin change flag and pin-0 edge flag.
// Assumes: single clock; strobes one cycle wide; W > CHG_LO.
module pinport_irq #(
    parameter int W       = 8,
    parameter int CHG_LO  = 4,
    parameter int CYC_DIV = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_in,
    input  logic         lat_wr,
    input  logic         dir_wr,
    input  logic         cfg_wr,
    input  logic [W-1:0] wdata,
    input  logic         cfg_pu_off,
    input  logic         cfg_rise,
    input  logic         port_rd,
    output logic [W-1:0] rdata,
    input  logic         intf_clr,
    input  logic         chgf_clr,
    output logic [W-1:0] pin_out,
    output logic [W-1:0] pin_oe,
    output logic [W-1:0] pu_en,
    output logic         intf,
    output logic         chgf
);
    import pinport_pkg::*;
    localparam int NW = W - CHG_LO;

    logic [W-1:0] lvl;
    logic [W-1:0] lat;
    logic [W-1:0] dir;
    logic         samp_tick;
    pport_cfg_t   cfg;

    pinport_sync #(.W(W), .DIV(CYC_DIV)) u_sync (
        .clk(clk), .rst_n(rst_n), .pins_raw(pin_in), .lvl(lvl), .tick(samp_tick)
    );

    pinport_regs #(.W(W)) u_regs (
        .clk(clk), .rst_n(rst_n), .lat_wr(lat_wr), .dir_wr(dir_wr),
        .cfg_wr(cfg_wr), .wdata(wdata), .cfg_pu_off(cfg_pu_off),
        .cfg_rise(cfg_rise), .lat(lat), .dir(dir), .cfg(cfg), .pu_en(pu_en)
    );

    pinport_chg #(.NW(NW)) u_chg (
        .clk(clk), .rst_n(rst_n), .lvl(lvl[W-1:CHG_LO]), .is_in(dir[W-1:CHG_LO]),
        .snap_load(port_rd | lat_wr), .clr(chgf_clr), .flag(chgf)
    );

    pinport_edge u_edge (
        .clk(clk), .rst_n(rst_n), .lvl(lvl[0]), .rise_sel(cfg.rise),
        .clr(intf_clr), .flag(intf)
    );

    assign rdata   = lvl;
    assign pin_out = lat;
    assign pin_oe  = ~dir;
endmodule

// File: rtl/pinport_irq_chk.sv
// Checker for pinport_irq: protocol and output properties, bound to the top.
// Assumes: strobes are one clock wide.
module pinport_irq_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         lat_wr,
    input logic         dir_wr,
    input logic [W-1:0] wdata,
    input logic [W-1:0] rdata,
    input logic         intf_clr,
    input logic         chgf_clr,
    input logic [W-1:0] pin_out,
    input logic [W-1:0] pin_oe,
    input logic [W-1:0] pu_en,
    input logic         intf,
    input logic         chgf,
    input logic         samp_tick
);
    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (pin_oe == '0 && pu_en == '0 && !intf && !chgf && pin_out == '0));

    p_dir_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        dir_wr |=> (pin_oe == ~$past(wdata)));

    p_latch_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        lat_wr |=> (pin_out == $past(wdata)));

    p_no_pullup_on_output_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pu_en & pin_oe) == '0);

    p_chgf_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (chgf && !chgf_clr) |=> chgf);

    p_intf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (intf && !intf_clr) |=> intf);

    p_sample_only_on_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !samp_tick |=> $stable(rdata));
endmodule

bind pinport_irq pinport_irq_chk #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .lat_wr(lat_wr), .dir_wr(dir_wr), .wdata(wdata),
    .rdata(rdata), .intf_clr(intf_clr), .chgf_clr(chgf_clr), .pin_out(pin_out),
    .pin_oe(pin_oe), .pu_en(pu_en), .intf(intf), .chgf(chgf), .samp_tick(samp_tick)
);

// File: tb/pinport_irq_test.sv
// Scoreboard bench for pinport_irq.
module pinport_irq_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] pin_in = 8'h00;
    logic       lat_wr = 1'b0, dir_wr = 1'b0, cfg_wr = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic       cfg_pu_off = 1'b1, cfg_rise = 1'b1;
    logic       port_rd = 1'b0, intf_clr = 1'b0, chgf_clr = 1'b0;
    logic [7:0] rdata, pin_out, pin_oe, pu_en;
    logic       intf, chgf;

    int errors = 0;
    int checks = 0;
    int edges  = 0;
    bit done   = 1'b0;

    typedef struct {
        int         sel;
        logic [7:0] exp;
        string      tag;
    } item_t;
    item_t sb[$];

    pinport_irq uut (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .lat_wr(lat_wr), .dir_wr(dir_wr),
        .cfg_wr(cfg_wr), .wdata(wdata), .cfg_pu_off(cfg_pu_off), .cfg_rise(cfg_rise),
        .port_rd(port_rd), .rdata(rdata), .intf_clr(intf_clr), .chgf_clr(chgf_clr),
        .pin_out(pin_out), .pin_oe(pin_oe), .pu_en(pu_en), .intf(intf), .chgf(chgf)
    );

    always #10 clk = ~clk;

    // Clock edges since reset release, used to place glitches between samples.
    always @(posedge clk) if (rst_n) edges <= edges + 1;

    function automatic logic [7:0] pick(int sel);
        case (sel)
            0: return rdata;
            1: return pin_out;
            2: return pin_oe;
            3: return pu_en;
            4: return {7'd0, intf};
            default: return {7'd0, chgf};
        endcase
    endfunction

    // Driver side: queue an expectation for the monitor.
    task automatic expect_out(int sel, logic [7:0] exp, string tag);
        sb.push_back('{sel: sel, exp: exp, tag: tag});
    endtask

    // Monitor: compare queued items between clock edges.
    initial begin
        forever begin
            wait (sb.size() != 0);
            #1;
            while (sb.size() != 0) begin
                item_t it;
                logic [7:0] act;
                it  = sb.pop_front();
                act = pick(it.sel);
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic settle();
        repeat (12) @(negedge clk);
    endtask

    task automatic wr_lat(logic [7:0] d);
        @(negedge clk); wdata = d; lat_wr = 1'b1;
        @(negedge clk); lat_wr = 1'b0;
    endtask

    task automatic wr_dir(logic [7:0] d);
        @(negedge clk); wdata = d; dir_wr = 1'b1;
        @(negedge clk); dir_wr = 1'b0;
    endtask

    task automatic wr_cfg(logic pu_off, logic rise);
        @(negedge clk); cfg_pu_off = pu_off; cfg_rise = rise; cfg_wr = 1'b1;
        @(negedge clk); cfg_wr = 1'b0;
    endtask

    task automatic rd_port();
        @(negedge clk); port_rd = 1'b1;
        @(negedge clk); port_rd = 1'b0;
    endtask

    task automatic clr_chg();
        @(negedge clk); chgf_clr = 1'b1;
        @(negedge clk); chgf_clr = 1'b0;
    endtask

    task automatic clr_int();
        @(negedge clk); intf_clr = 1'b1;
        @(negedge clk); intf_clr = 1'b0;
    endtask

    // Watchdog: a hung run is counted as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        expect_out(2, 8'h00, "R1 pin_oe");
        expect_out(1, 8'h00, "R1 pin_out");
        expect_out(3, 8'h00, "R1 pu_en");
        expect_out(4, 8'h00, "R1 intf");
        expect_out(5, 8'h00, "R1 chgf");
        @(negedge clk);

        // R2 latch and direction
        wr_lat(8'hA5);
        wr_dir(8'hF1);
        expect_out(1, 8'hA5, "R2 pin_out");
        expect_out(2, 8'h0E, "R2 pin_oe");
        @(negedge clk);

        // R4 pull-ups on input pins only
        wr_cfg(1'b0, 1'b1);
        expect_out(3, 8'hF1, "R4 pu_en enabled");
        @(negedge clk);

        // R3/R5 low pins change: read sees it, no change flag
        pin_in = 8'h0C;
        settle();
        expect_out(0, 8'h0C, "R3 rdata");
        expect_out(5, 8'h00, "R5 low pins ignored");
        @(negedge clk);

        // R5 upper pin configured as output is ignored
        wr_dir(8'hE1);
        pin_in = 8'h1C;
        settle();
        expect_out(5, 8'h00, "R5 output pin ignored");
        @(negedge clk);
        rd_port();
        wr_dir(8'hF1);
        settle();
        expect_out(5, 8'h00, "R5 after re-enable");
        @(negedge clk);

        // R5/R6 upper input change sets flag, sticky until read
        pin_in = 8'h9C;
        settle();
        expect_out(5, 8'h01, "R5 upper change");
        @(negedge clk);
        clr_chg();
        expect_out(5, 8'h01, "R6 clear blocked by mismatch");
        @(negedge clk);
        rd_port();
        expect_out(0, 8'h9C, "R3 rdata upper");
        @(negedge clk);
        clr_chg();
        expect_out(5, 8'h00, "R6 clear after read");
        @(negedge clk);

        // R7 latch write refreshes snapshot; R3 rdata unaffected
        pin_in = 8'h1C;
        settle();
        expect_out(5, 8'h01, "R7 mismatch present");
        @(negedge clk);
        wr_lat(8'h5A);
        clr_chg();
        expect_out(5, 8'h00, "R7 clear after latch write");
        expect_out(1, 8'h5A, "R2 pin_out second");
        expect_out(0, 8'h1C, "R3 rdata after latch write");
        @(negedge clk);

        // R9 one-clock glitch between samples is missed
        do @(negedge clk); while (edges % 4 != 0);
        pin_in = 8'h9C;
        @(negedge clk);
        pin_in = 8'h1C;
        settle();
        expect_out(5, 8'h00, "R9 glitch missed");
        expect_out(0, 8'h1C, "R9 rdata after glitch");
        @(negedge clk);

        // R8 rising edge
        pin_in = 8'h1D;
        settle();
        expect_out(4, 8'h01, "R8 rising edge");
        expect_out(5, 8'h00, "R5 pin0 not in change set");
        @(negedge clk);
        clr_int();
        expect_out(4, 8'h00, "R8 clear");
        @(negedge clk);

        // R8 falling edge selected
        wr_cfg(1'b0, 1'b0);
        pin_in = 8'h1C;
        settle();
        expect_out(4, 8'h01, "R8 falling edge");
        @(negedge clk);
        clr_int();
        pin_in = 8'h1D;
        settle();
        expect_out(4, 8'h00, "R8 rising ignored in falling mode");
        @(negedge clk);

        // R4 disable and output pins
        wr_cfg(1'b1, 1'b0);
        expect_out(3, 8'h00, "R4 disabled");
        @(negedge clk);
        wr_cfg(1'b0, 1'b0);
        wr_dir(8'h00);
        expect_out(3, 8'h00, "R4 all outputs");
        expect_out(2, 8'hFF, "R2 all driving");
        @(negedge clk);
        @(negedge clk);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule